// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address using a two-level page table with 4 KiB pages and 4 MiB superpages. A requester presents an address together with an access kind (instruction fetch, data load or data store) and a privilege level. The walker also samples the translation-enable bit, the root page number and the status bits that change how access is checked: modify-privilege, previous privilege, supervisor-user access and make-executable-readable. It then reads page table entries one at a time through a simple memory port.

Each entry is checked against the full leaf rule chain. This covers validity, the two reserved permission encodings, user and supervisor ownership, superpage alignment and the permission that the access kind needs. When the walk succeeds, the accessed bit is set, and for a store the dirty bit is also set. The entry is written back only when one of those bits changed. The walker reports success or fault, the physical address and the read, write and execute rights that apply to the page. It has no translation cache and handles one request at a time.

Page table entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 6 accessed, bit 7 dirty, bits 31:10 physical page number. Privilege codes are 0 user, 1 supervisor and 3 machine. Access codes are 0 fetch, 1 load and 2 store.

Top module: `sv32_walker`

## Requirements
- R1: When translation is disabled, or the effective privilege is machine, the walker reads no memory. It reports success, a physical address equal to the zero-extended virtual address and all three rights set. `done` rises in the cycle after the request is accepted.
- R2: For a load or store at machine privilege with modify-privilege set, the effective privilege is the previous-privilege field. A fetch ignores modify-privilege.
- R3: The first entry is read at root_ppn*4096 + vaddr[31:22]*4. A pointer entry (read, write and execute all clear) moves the walk one level down, and the next entry is read at its page number*4096 + vaddr[21:12]*4.
- R4: An entry whose valid bit is clear ends the walk with a fault.
- R5: A pointer entry found at the last level ends the walk with a fault.
- R6: A leaf with write set and read clear (write only, or write plus execute) is reserved and faults.
- R7: A user page accessed at a non-user privilege faults when supervisor-user access is clear, and always faults for a fetch. At user privilege the page is allowed.
- R8: A page without the user bit faults at every effective privilege other than supervisor.
- R9: A first-level leaf whose page number has any of its low 10 bits set is a misaligned superpage and faults.
- R10: A load needs read, or execute with make-executable-readable set. A store needs write. A fetch needs execute.
- R11: On success the entry is updated with accessed set, and with dirty set for a store. It is written back to the address it was read from only if it changed.
- R12: The physical address is {page number, vaddr[11:0]} for a 4 KiB page and {page number[21:10], vaddr[21:0]} for a superpage. The read right is read OR (execute AND make-executable-readable), the execute right is execute, and the write right is write AND (store OR dirty). A fault reports zero address and zero rights.
- R13: `mem_req` stays high, with a stable address and direction, until `mem_rvalid`. `done` is a single-cycle pulse. A request offered while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| xlat_on | input | 1 | Translation enable |
| root_ppn | input | 22 | Root table page number |
| mprv | input | 1 | Modify-privilege for loads and stores |
| mpp | input | 2 | Previous privilege used under modify-privilege |
| sum | input | 1 | Supervisor access to user pages |
| mxr | input | 1 | Executable pages readable by loads |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (entry write-back) |
| mem_addr | output | 34 | Entry address |
| mem_wdata | output | 32 | Updated entry |
| mem_rvalid | input | 1 | Read data valid or write acknowledge |
| mem_rdata | input | 32 | Entry read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation failed |
| paddr | output | 34 | Physical address |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right |
| perm_x | output | 1 | Execute right |

## Verification
The bench builds the walker with its default parameters: two levels, 10 index bits, 12 offset bits, 32-bit entries and 34-bit physical addresses. With these values a walk reaches both the 4 KiB leaf level and a first-level superpage, so the alignment and address-splicing rules both get exercised. The bench's memory model answers after a programmable latency, which lets the same walks run with zero-wait and multi-cycle responses. A second request held during a slow walk shows that it is ignored.

// File: rtl/sv32_walker.sv
module sv32_walker #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 32,
  parameter int PPN_W  = 22,
  parameter int PA_W   = 34
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [OFF_W+LEVELS*IDX_W-1:0] req_vaddr,
  input  logic [1:0]                    req_acc,
  input  logic [1:0]                    req_priv,
  input  logic                          xlat_on,
  input  logic [PPN_W-1:0]              root_ppn,
  input  logic                          mprv,
  input  logic [1:0]                    mpp,
  input  logic                          sum,
  input  logic                          mxr,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [PA_W-1:0]               mem_addr,
  output logic [PTE_W-1:0]              mem_wdata,
  input  logic                          mem_rvalid,
  input  logic [PTE_W-1:0]              mem_rdata,
  output logic                          busy,
  output logic                          done,
  output logic                          fault,
  output logic [PA_W-1:0]               paddr,
  output logic                          perm_r,
  output logic                          perm_w,
  output logic                          perm_x
);
  localparam int VA_W   = OFF_W + LEVELS * IDX_W;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PTE_SH = $clog2(PTE_W / 8);
  localparam logic [1:0] PRIV_U = 2'd0, PRIV_S = 2'd1, PRIV_M = 2'd3;
  localparam logic [1:0] ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2;
  localparam int B_V = 0, B_R = 1, B_W = 2, B_X = 3, B_U = 4, B_A = 6, B_D = 7;

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_CHECK, ST_WB, ST_DONE} st_t;

  st_t               st;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q, eff_q;
  logic              sum_q, mxr_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   base_q;
  logic [PTE_W-1:0]  pte_q;
  logic              fault_q, r_q, w_q, x_q;
  logic [PA_W-1:0]   paddr_q;

  logic [1:0]        eff_in;
  logic              pass_in;
  logic [IDX_W-1:0]  idx;
  logic [PPN_W-1:0]  ppn, low_mask, vpn_ext, leaf_ppn;
  logic              f_v, f_r, f_w, f_x, f_u, f_d;
  logic              is_ptr, rsvd, priv_bad, misal, acc_bad, leaf_bad, is_store;
  logic [PTE_W-1:0]  upd_pte;

  assign eff_in  = (req_priv == PRIV_M && req_acc != ACC_FETCH && mprv) ? mpp : req_priv;
  assign pass_in = !xlat_on || eff_in == PRIV_M;

  assign idx      = IDX_W'(va_q >> (OFF_W + 32'(lvl_q) * IDX_W));
  assign ppn      = pte_q[PTE_W-1 -: PPN_W];
  assign low_mask = PPN_W'((64'd1 << (32'(lvl_q) * IDX_W)) - 64'd1);
  assign vpn_ext  = PPN_W'(va_q[VA_W-1:OFF_W]);
  assign leaf_ppn = (ppn & ~low_mask) | (vpn_ext & low_mask);

  assign f_v = pte_q[B_V];
  assign f_r = pte_q[B_R];
  assign f_w = pte_q[B_W];
  assign f_x = pte_q[B_X];
  assign f_u = pte_q[B_U];
  assign f_d = pte_q[B_D];
  assign is_store = acc_q == ACC_STORE;

  assign is_ptr   = !f_r && !f_w && !f_x;
  assign rsvd     = f_w && !f_r;
  assign priv_bad = f_u ? (eff_q != PRIV_U && (!sum_q || acc_q == ACC_FETCH))
                        : (eff_q != PRIV_S);
  assign misal    = |(ppn & low_mask);

  always_comb begin
    case (acc_q)
      ACC_LOAD:  acc_bad = !(f_r || (f_x && mxr_q));
      ACC_STORE: acc_bad = !f_w;
      ACC_FETCH: acc_bad = !f_x;
      default:   acc_bad = 1'b1;
    endcase
    upd_pte = pte_q;
    upd_pte[B_A] = 1'b1;
    if (is_store) upd_pte[B_D] = 1'b1;
  end

  assign leaf_bad = rsvd || priv_bad || misal || acc_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_FETCH;
      eff_q   <= PRIV_U;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      fault_q <= 1'b0;
      paddr_q <= '0;
      r_q     <= 1'b0;
      w_q     <= 1'b0;
      x_q     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          acc_q <= req_acc;
          eff_q <= eff_in;
          sum_q <= sum;
          mxr_q <= mxr;
          if (pass_in) begin
            fault_q <= 1'b0;
            paddr_q <= PA_W'(req_vaddr);
            {r_q, w_q, x_q} <= 3'b111;
            st <= ST_DONE;
          end else begin
            base_q <= PA_W'({root_ppn, {OFF_W{1'b0}}});
            lvl_q  <= LVL_W'(LEVELS - 1);
            st     <= ST_READ;
          end
        end
        ST_READ: if (mem_rvalid) begin
          pte_q <= mem_rdata;
          st    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!f_v || (is_ptr && lvl_q == '0) || (!is_ptr && leaf_bad)) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            {r_q, w_q, x_q} <= 3'b000;
            st <= ST_DONE;
          end else if (is_ptr) begin
            base_q <= PA_W'({ppn, {OFF_W{1'b0}}});
            lvl_q  <= lvl_q - 1'b1;
            st     <= ST_READ;
          end else begin
            fault_q <= 1'b0;
            paddr_q <= PA_W'({leaf_ppn, va_q[OFF_W-1:0]});
            r_q <= f_r || (f_x && mxr_q);
            w_q <= f_w && (is_store || f_d);
            x_q <= f_x;
            if (upd_pte != pte_q) begin
              pte_q <= upd_pte;
              st    <= ST_WB;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_WB:   if (mem_rvalid) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = st != ST_IDLE;
  assign done      = st == ST_DONE;
  assign mem_req   = st == ST_READ || st == ST_WB;
  assign mem_we    = st == ST_WB;
  assign mem_addr  = base_q + (PA_W'(idx) << PTE_SH);
  assign mem_wdata = pte_q;
  assign fault     = fault_q;
  assign paddr     = paddr_q;
  assign perm_r    = r_q;
  assign perm_w    = w_q;
  assign perm_x    = x_q;

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  p_wb_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_A] && mem_wdata[B_V]);
  p_wb_same_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> mem_addr == $past(mem_addr));
  p_fault_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> !perm_r && !perm_w && !perm_x && paddr == '0);
  p_wb_not_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !(mem_wdata[B_W] && !mem_wdata[B_R]));
endmodule

// File: tb/tb_sv32_walker.sv
`timescale 1ns/1ps
module tb_sv32_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0, req_priv = '0;
  logic        xlat_on = 1'b0;
  logic [21:0] root_ppn = 22'h00100;
  logic        mprv = 1'b0;
  logic [1:0]  mpp = 2'd0;
  logic        sum = 1'b0, mxr = 1'b0;
  logic        mem_req, mem_we;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        busy, done, fault, perm_r, perm_w, perm_x;
  logic [33:0] paddr;

  sv32_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_priv(req_priv), .xlat_on(xlat_on), .root_ppn(root_ppn),
    .mprv(mprv), .mpp(mpp), .sum(sum), .mxr(mxr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault), .paddr(paddr),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x));

  always #2.5 clk = ~clk;

  localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;
  localparam logic [1:0] FET = 2'd0, LD = 2'd1, ST = 2'd2;
  localparam logic [9:0] FV = 10'h001, FR = 10'h002, FW = 10'h004, FX = 10'h008,
                         FU = 10'h010, FA = 10'h040, FD = 10'h080;
  localparam logic [31:0] VA = 32'h0140A123;
  localparam logic [33:0] ROOT_E = 34'h100014;
  localparam logic [33:0] L0_E   = 34'h200028;
  localparam logic [21:0] LEAF_PPN = 22'h12345;
  localparam logic [33:0] PA4K = {LEAF_PPN, 12'h123};

  logic [31:0] mem [logic [33:0]];
  int          lat = 0;
  int          wait_c = 0;
  logic        rvalid_r = 1'b0;
  logic [31:0] rdata_r = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [33:0] rd_log [0:7];
  logic [33:0] wr_addr_l = '0;
  logic [31:0] wr_data_l = '0;
  assign mem_rvalid = rvalid_r;
  assign mem_rdata  = rdata_r;

  always @(posedge clk) begin
    if (rvalid_r) rvalid_r <= 1'b0;
    else if (mem_req) begin
      if (wait_c >= lat) begin
        rvalid_r <= 1'b1;
        wait_c   <= 0;
        if (mem_we) begin
          wr_cnt    <= wr_cnt + 1;
          wr_addr_l <= mem_addr;
          wr_data_l <= mem_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1;
          rd_log[rd_cnt[2:0]] <= mem_addr;
          rdata_r <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
      end else wait_c <= wait_c + 1;
    end
  end

  int nchk = 0, nfail = 0;
  logic        res_f, res_r, res_w, res_x;
  logic [33:0] res_pa;
  int          res_rd, res_wr, rd_base;

  function automatic logic [31:0] pte(input logic [21:0] p, input logic [9:0] f);
    return {p, f};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] leaf);
    mem.delete();
    mem[ROOT_E] = pte(22'h00200, FV);
    mem[L0_E]   = leaf;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv);
    int r0, w0, n;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_priv = priv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R13 walk timeout: actual done=0 expected done=1");
    end
    res_f = fault; res_pa = paddr; res_r = perm_r; res_w = perm_w; res_x = perm_x;
    res_rd = rd_cnt - r0; res_wr = wr_cnt - w0; rd_base = r0;
  endtask

  task automatic chk_fault(input string req, input string what);
    chk(req, {what, " fault"}, res_f, 1);
    chk(req, {what, " rights"}, {res_r, res_w, res_x}, 0);
    chk(req, {what, " paddr"}, res_pa, 0);
  endtask

  task automatic t_reset;
    chk("R13", "reset busy", busy, 0);
    chk("R13", "reset done", done, 0);
    chk("R13", "reset mem_req", mem_req, 0);
    chk("R12", "reset fault", fault, 0);
  endtask

  task automatic t_bare;
    int n;
    xlat_on = 1'b0; build(pte(LEAF_PPN, FV | FR | FA | FD));
    do_walk(VA, ST, S);
    chk("R1", "bare paddr", res_pa, {2'b00, VA});
    chk("R1", "bare rights", {res_f, res_r, res_w, res_x}, 4'b0111);
    chk("R1", "bare reads", res_rd, 0);
    xlat_on = 1'b1;
    do_walk(VA, LD, M);
    chk("R1", "machine passthrough", res_pa, {2'b00, VA});
    chk("R1", "machine reads", res_rd, 0);
    @(negedge clk);
    req_vaddr = VA; req_acc = LD; req_priv = M; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "done one cycle after accept", done, 1);
    n = 0;
    while (done && n < 10) begin @(negedge clk); n++; end
  endtask

  task automatic t_mprv;
    xlat_on = 1'b1; build(pte(LEAF_PPN, FV | FR | FA | FD));
    mprv = 1'b1; mpp = S;
    do_walk(VA, LD, M);
    chk("R2", "mprv S load paddr", res_pa, PA4K);
    chk("R2", "mprv S load reads", res_rd, 2);
    mpp = U;
    do_walk(VA, LD, M);
    chk("R2", "mprv U on supervisor page", res_f, 1);
    do_walk(VA, FET, M);
    chk("R2", "fetch ignores mprv", res_pa, {2'b00, VA});
    chk("R2", "fetch ignores mprv reads", res_rd, 0);
    mprv = 1'b0; mpp = U;
  endtask

  task automatic t_4k;
    lat = 2; build(pte(LEAF_PPN, FV | FR | FA | FD));
    do_walk(VA, LD, S);
    chk("R3", "first entry address", rd_log[rd_base % 8], ROOT_E);
    chk("R3", "second entry address", rd_log[(rd_base + 1) % 8], L0_E);
    chk("R12", "4k paddr", res_pa, PA4K);
    chk("R12", "4k rights", {res_f, res_r, res_w, res_x}, 4'b0100);
    chk("R11", "no write when unchanged", res_wr, 0);
    lat = 0;
  endtask

  task automatic t_ad;
    build(pte(LEAF_PPN, FV | FR | FW));
    do_walk(VA, ST, S);
    chk("R11", "store writes once", res_wr, 1);
    chk("R11", "store write address", wr_addr_l, L0_E);
    chk("R11", "store write data", wr_data_l, pte(LEAF_PPN, FV | FR | FW | FA | FD));
    chk("R12", "store write right", res_w, 1);
    do_walk(VA, LD, S);
    chk("R11", "load write data", wr_data_l, pte(LEAF_PPN, FV | FR | FW | FA));
    chk("R12", "load clean page no write right", {res_r, res_w}, 2'b10);
    build(pte(LEAF_PPN, FV | FR | FW | FA | FD));
    do_walk(VA, LD, S);
    chk("R11", "dirty page load no write", res_wr, 0);
    chk("R12", "dirty page write right", res_w, 1);
  endtask

  task automatic t_invalid;
    build(pte(LEAF_PPN, FR | FA | FD));
    do_walk(VA, LD, S);
    chk_fault("R4", "leaf valid clear");
    mem[ROOT_E] = pte(22'h00200, 10'h0);
    do_walk(VA, LD, S);
    chk("R4", "root invalid fault", res_f, 1);
    chk("R4", "root invalid reads", res_rd, 1);
  endtask

  task automatic t_ptr_end;
    build(pte(22'h00300, FV));
    do_walk(VA, LD, S);
    chk_fault("R5", "pointer at last level");
    chk("R5", "pointer at last level reads", res_rd, 2);
  endtask

  task automatic t_rsvd;
    build(pte(LEAF_PPN, FV | FW | FA | FD));
    do_walk(VA, ST, S);
    chk("R6", "write-only leaf", res_f, 1);
    chk("R6", "write-only no write-back", res_wr, 0);
    build(pte(LEAF_PPN, FV | FW | FX | FA | FD));
    do_walk(VA, FET, S);
    chk("R6", "write+exec leaf", res_f, 1);
  endtask

  task automatic t_user;
    build(pte(LEAF_PPN, FV | FR | FX | FU | FA | FD));
    sum = 1'b0;
    do_walk(VA, LD, S);
    chk("R7", "S load user page sum=0", res_f, 1);
    sum = 1'b1;
    do_walk(VA, LD, S);
    chk("R7", "S load user page sum=1", res_f, 0);
    do_walk(VA, FET, S);
    chk("R7", "S fetch user page sum=1", res_f, 1);
    sum = 1'b0;
    do_walk(VA, FET, U);
    chk("R7", "U fetch user page", {res_f, res_x}, 2'b01);
  endtask

  task automatic t_supv;
    build(pte(LEAF_PPN, FV | FR | FA | FD));
    do_walk(VA, LD, U);
    chk("R8", "U load supervisor page", res_f, 1);
    do_walk(VA, LD, S);
    chk("R8", "S load supervisor page", res_f, 0);
  endtask

  task automatic t_super;
    logic [33:0] exp;
    mem.delete();
    mem[ROOT_E] = pte(22'h00C00, FV | FR | FW | FA | FD);
    lat = 1;
    do_walk(VA, ST, S);
    exp = {22'h00C00, 12'h000} | {12'h0, VA[21:0]};
    chk("R12", "superpage paddr", res_pa, exp);
    chk("R12", "superpage reads", res_rd, 1);
    chk("R9", "aligned superpage ok", res_f, 0);
    mem[ROOT_E] = pte(22'h00C01, FV | FR | FW | FA | FD);
    do_walk(VA, LD, S);
    chk_fault("R9", "misaligned superpage");
    lat = 0;
  endtask

  task automatic t_access;
    build(pte(LEAF_PPN, FV | FX | FA));
    mxr = 1'b0;
    do_walk(VA, LD, S);
    chk("R10", "load exec-only mxr=0", res_f, 1);
    mxr = 1'b1;
    do_walk(VA, LD, S);
    chk("R10", "load exec-only mxr=1", {res_f, res_r, res_w, res_x}, 4'b0101);
    mxr = 1'b0;
    build(pte(LEAF_PPN, FV | FR | FA | FD));
    do_walk(VA, FET, S);
    chk("R10", "fetch read-only page", res_f, 1);
    do_walk(VA, ST, S);
    chk("R10", "store read-only page", res_f, 1);
  endtask

  task automatic t_busy;
    int n;
    lat = 3; build(pte(LEAF_PPN, FV | FR | FA | FD));
    @(negedge clk);
    req_vaddr = VA; req_acc = LD; req_priv = S; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h00000FFF; req_priv = M;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    chk("R13", "busy request ignored paddr", paddr, PA4K);
    chk("R13", "busy request ignored fault", fault, 0);
    @(negedge clk);
    chk("R13", "done single cycle", done, 0);
    @(negedge clk);
    chk("R13", "idle after held request", busy, 0);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_bare;
    t_mprv;
    t_4k;
    t_ad;
    t_invalid;
    t_ptr_end;
    t_rsvd;
    t_user;
    t_supv;
    t_super;
    t_access;
    t_busy;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R13 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule